// File: doc/BRIEF.md
# Serial-Loaded Switch Enable Controller

This block is the digital control core of a small analog switch array. A host writes an enable word over a three-wire serial link made of an active-low frame line, a serial clock and a data line. Each bit of the word drives one switch-enable output, and the outputs change only when a frame closes. A serial output carries the bits as they leave the shift register, so several units can share one frame line in a chain, or the host can read back what it wrote last.

All three serial inputs pass through multi-flop synchronisers into one fast system clock, and edges are detected there. When a frame closes, a four-state sequencer applies the new word with break-before-make. `ST_IDLE` goes to `ST_BREAK` on an update request. `ST_BREAK` opens every switch that is leaving and then always goes to `ST_DEAD`. `ST_DEAD` counts `DEAD_CYC` system cycles and goes to `ST_MAKE` when the count reaches zero. `ST_MAKE` closes the new switches. From `ST_MAKE` the sequencer goes back to `ST_BREAK` if a request is waiting or arriving, and otherwise returns to `ST_IDLE`. A frame that closes while a sequence is running is held in a one-deep queue, and a newer frame replaces it.

Top module: `swc_ctrl`

## Requirements
- R1: While `frame_n` is high, toggling `sclk` and `sdi` changes neither the shift register nor `sw_en`.
- R2: While `frame_n` is low, one `sdi` bit is shifted in on each falling edge of `sclk`, most significant bit first. After an 8-bit frame, the first bit sent drives `sw_en[7]` and the last bit sent drives `sw_en[0]`.
- R3: A 1 at bit position k closes switch k (`sw_en[k]`=1) and a 0 opens it. All-ones and all-zeros words are both legal.
- R4: A frame of any length, shorter or longer than eight clocks, leaves the last eight bits shifted in as the word.
- R5: `sw_en` changes only after a rising edge of `frame_n`. During a frame it keeps the previously applied word.
- R6: `sdo` changes only on a rising edge of `sclk` while `frame_n` is low, and it then shows the current shift register MSB. Clocking a frame therefore returns the word held before that frame, MSB first.
- R7: A low level on `clr_n`, sampled by `clk`, empties the shift register, clears `sdo` and drives every `sw_en` bit to 0 on the next edge.
- R8: After `rst_n` the shift register is zero, `sdo` is 0 and all switches are open until a frame completes.
- R9: On an update, no enable rises until at least `DEAD_CYC` system cycles after the switches that are leaving have opened.
- R10: A switch that is closed in both the old and the new word keeps its enable high throughout the update.
- R11: A frame that closes while an update is still running is applied once that update has finished, so the first word is seen and the final state is the later word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Active-low clear, sampled by `clk` |
| frame_n | input | 1 | Active-low frame select; its rising edge applies the word |
| sclk | input | 1 | Serial clock; data in on the falling edge, data out on the rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out, for chaining and readback |
| sw_en | output | N_SW | One close-enable per switch |

## Verification
The bench goes after frames with lengths from one to twelve bits. A design that kept the first eight bits instead of the last, or that shifted LSB first, would apply the wrong word. Readback through `sdo` also catches a serial output that moves on the wrong clock edge or that lags by one bit. A background monitor measures the gap between every opening and the next closing, which exposes a sequencer that makes before it breaks. The same monitor watches bits held across a 0xF0 to 0x3C update, so a glitch on a switch that stays closed is reported. Two frames sent back to back inside the dead time show whether a queued update is lost. Clocking noise with the frame line high, followed by a readback, shows whether the idle bus corrupts the register.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BREAK = 2'd1,
        ST_DEAD  = 2'd2,
        ST_MAKE  = 2'd3
    } bbm_state_t;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/swc_shift.sv
module swc_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         act,
    input  logic         sh_fall,
    input  logic         sh_rise,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            dout <= 1'b0;
        end else if (!clr_n) begin
            word <= '0;
            dout <= 1'b0;
        end else if (act) begin
            if (sh_fall) word <= {word[W-2:0], din};
            if (sh_rise) dout <= word[W-1];
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && clr_n) |=> $stable(word)); // R1
    AST_SDO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !sh_rise) |=> $stable(dout)); // R6
endmodule

// File: rtl/swc_bbm.sv
module swc_bbm
    import swc_pkg::*;
#(
    parameter int W        = 8,
    parameter int DEAD_CYC = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         upd,
    input  logic [W-1:0] word,
    output logic [W-1:0] en_q
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(DEAD_CYC - 1);

    bbm_state_t    state_q, state_d;
    logic [W-1:0]  tgt_q, pend_word;
    logic          pend_vld;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (upd) state_d = ST_BREAK;
            ST_BREAK: state_d = ST_DEAD;
            ST_DEAD:  if (cnt_q == '0) state_d = ST_MAKE;
            ST_MAKE:  state_d = (upd || pend_vld) ? ST_BREAK : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= ST_IDLE;
        else if (!clr_n) state_q <= ST_IDLE;
        else             state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            tgt_q     <= '0;
            pend_word <= '0;
            pend_vld  <= 1'b0;
            cnt_q     <= '0;
        end else if (!clr_n) begin
            en_q      <= '0;
            tgt_q     <= '0;
            pend_word <= '0;
            pend_vld  <= 1'b0;
            cnt_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (upd) tgt_q <= word;
                end
                ST_BREAK: begin
                    en_q  <= en_q & tgt_q;
                    cnt_q <= CNT_LOAD;
                    if (upd) begin
                        pend_vld  <= 1'b1;
                        pend_word <= word;
                    end
                end
                ST_DEAD: begin
                    if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                    if (upd) begin
                        pend_vld  <= 1'b1;
                        pend_word <= word;
                    end
                end
                ST_MAKE: begin
                    en_q <= tgt_q;
                    if (upd) begin
                        tgt_q    <= word;
                        pend_vld <= 1'b0;
                    end else if (pend_vld) begin
                        tgt_q    <= pend_word;
                        pend_vld <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_NO_EARLY_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_MAKE) |=> ((en_q & ~$past(en_q)) == '0)); // R9
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= CNT_LOAD)); // R9
    AST_KEEP_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && state_q == ST_MAKE) |=> ((~en_q & $past(en_q)) == '0)); // R10
    AST_QUEUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && upd && state_q == ST_DEAD) |=> pend_vld); // R11
endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl #(
    parameter int N_SW        = 8,
    parameter int DEAD_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_n,
    input  logic            frame_n,
    input  logic            sclk,
    input  logic            sdi,
    output logic            sdo,
    output logic [N_SW-1:0] sw_en
);
    localparam int IDX_FRM = 2;
    localparam int IDX_CLK = 1;
    localparam int IDX_DAT = 0;

    logic [2:0]      raw_in, syn_in;
    logic            frame_prev, sclk_prev;
    logic            upd, act, sh_fall, sh_rise;
    logic [N_SW-1:0] sh_word;

    assign raw_in = {frame_n, sclk, sdi};

    swc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .q     (syn_in)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_prev <= 1'b1;
            sclk_prev  <= 1'b0;
        end else begin
            frame_prev <= syn_in[IDX_FRM];
            sclk_prev  <= syn_in[IDX_CLK];
        end
    end

    assign upd     = syn_in[IDX_FRM] & ~frame_prev;
    assign act     = ~syn_in[IDX_FRM];
    assign sh_fall = ~syn_in[IDX_CLK] & sclk_prev;
    assign sh_rise = syn_in[IDX_CLK] & ~sclk_prev;

    swc_shift #(.W(N_SW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .act     (act),
        .sh_fall (sh_fall),
        .sh_rise (sh_rise),
        .din     (syn_in[IDX_DAT]),
        .word    (sh_word),
        .dout    (sdo)
    );

    swc_bbm #(.W(N_SW), .DEAD_CYC(DEAD_CYC)) u_bbm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .upd   (upd),
        .word  (sh_word),
        .en_q  (sw_en)
    );

    AST_CLEAR_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (sw_en == '0 && sdo == 1'b0)); // R7
    AST_UPD_ONLY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && act) |=> $stable(sw_en)); // R5
endmodule

// File: tb/sim_swc_ctrl.sv
module sim_swc_ctrl;
    localparam int DEAD = 32;
    localparam int HALF = 4;
    localparam int SETTLE = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0, clr_n = 1'b1, frame_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo;
    logic [7:0] sw_en;

    always #10 clk = ~clk;

    swc_ctrl #(.N_SW(8), .DEAD_CYC(DEAD), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .frame_n(frame_n),
        .sclk(sclk), .sdi(sdi), .sdo(sdo), .sw_en(sw_en)
    );

    int n_chk = 0, n_bad = 0, mon_viol = 0, bbm_pairs = 0;
    logic [7:0] m_sr = '0, m_app = '0;
    logic [7:0] hold_mask = '0, watch_w = '0;
    logic saw_w = 1'b0, watch_on = 1'b0, done = 1'b0;

    function automatic logic [7:0] model_shift(logic [7:0] sr, logic b);
        return {sr[6:0], b};
    endfunction

    task automatic chk(string req, logic [31:0] act_v, logic [31:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(logic b, string tag);
        sdi  = b;
        sclk = 1'b1;
        tick(HALF);
        chk(tag, 32'(sdo), 32'(m_sr[7]));
        sclk = 1'b0;
        tick(HALF);
        m_sr = model_shift(m_sr, b);
    endtask

    task automatic send_frame(logic [15:0] bits, int len, bit check_en, int settle, string tag);
        frame_n = 1'b0;
        tick(4);
        for (int i = len - 1; i >= 0; i--) shift_bit(bits[i], tag);
        if (check_en) chk("R5 hold during frame", 32'(sw_en), 32'(m_app));
        frame_n = 1'b1;
        m_app = m_sr;
        tick(settle);
        if (check_en) chk({tag, " applied word"}, 32'(sw_en), 32'(m_app));
    endtask

    logic [7:0] en_prev = '0;
    int cyc = 0, last_fall = -1000000;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if ((en_prev & ~sw_en) != 8'h00) last_fall = cyc;
            if ((~en_prev & sw_en) != 8'h00) begin
                if (cyc - last_fall < DEAD) begin
                    mon_viol++;
                    $display("FAIL R9 gap actual=%0d expected>=%0d", cyc - last_fall, DEAD);
                end else if (cyc - last_fall < 4 * DEAD) bbm_pairs++;
            end
            if ((en_prev & hold_mask & ~sw_en) != 8'h00) begin
                mon_viol++;
                $display("FAIL R10 held bit dropped actual=%0h expected=%0h", sw_en, en_prev);
            end
            if (watch_on && sw_en == watch_w) saw_w = 1'b1;
        end
        en_prev = sw_en;
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        logic [15:0] rb;
        int ln;
        seed_v = $urandom(32'd4711);
        tick(3);
        rst_n = 1'b1;
        tick(3);
        chk("R8 reset enables", 32'(sw_en), 32'h0);
        chk("R8 reset sdo", 32'(sdo), 32'h0);
        send_frame(16'h00A5, 8, 1'b1, SETTLE, "R8 R2");
        chk("R2 msb order", 32'(sw_en), 32'h0A5);

        send_frame(16'h00FF, 8, 1'b1, SETTLE, "R3 ones");
        send_frame(16'h0000, 8, 1'b1, SETTLE, "R3 zeros");

        send_frame(16'h0003, 2, 1'b1, SETTLE, "R4 short");
        send_frame(16'h0ABC, 12, 1'b1, SETTLE, "R4 long");
        chk("R4 last eight", 32'(sw_en), 32'h0BC);

        frame_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            sclk = $urandom % 2;
            sdi  = $urandom % 2;
            tick(3);
        end
        sclk = 1'b0;
        tick(6);
        chk("R1 idle noise enables", 32'(sw_en), 32'(m_app));
        send_frame(16'h005A, 8, 1'b1, SETTLE, "R1 R6 readback");

        send_frame(16'h000F, 8, 1'b1, SETTLE, "R9 setup");
        send_frame(16'h00F0, 8, 1'b1, SETTLE, "R9 swap");
        chk("R9 pairs observed", 32'(bbm_pairs > 0), 32'h1);

        send_frame(16'h00F0, 8, 1'b1, SETTLE, "R10 setup");
        hold_mask = 8'h30;
        send_frame(16'h003C, 8, 1'b1, SETTLE, "R10 update");
        hold_mask = 8'h00;

        watch_w = 8'h81;
        saw_w = 1'b0;
        watch_on = 1'b1;
        send_frame(16'h0081, 8, 1'b0, 4, "R11 first");
        send_frame(16'h0002, 2, 1'b0, SETTLE, "R11 second");
        watch_on = 1'b0;
        chk("R11 first word seen", 32'(saw_w), 32'h1);
        chk("R11 final word", 32'(sw_en), 32'(m_app));
        chk("R11 final value", 32'(sw_en), 32'h006);

        send_frame(16'h00FF, 8, 1'b1, SETTLE, "R7 setup");
        clr_n = 1'b0;
        tick(1);
        clr_n = 1'b1;
        tick(1);
        chk("R7 enables cleared", 32'(sw_en), 32'h0);
        chk("R7 sdo cleared", 32'(sdo), 32'h0);
        m_sr = '0;
        m_app = '0;
        send_frame(16'h0033, 8, 1'b1, SETTLE, "R7 readback");

        for (int k = 0; k < 25; k++) begin
            ln = 1 + int'($urandom % 12);
            rb = 16'($urandom);
            send_frame(rb, ln, 1'b1, SETTLE, "R2 R4 R6 random");
        end

        chk("R9 R10 monitor violations", 32'(mon_viol), 32'h0);
        done = 1'b1;
        report();
        $finish;
    end
endmodule